// File: doc/BRIEF.md
# Byte-Serial Buffer DMA Engine

This block copies a run of bytes between a private 4096-byte buffer and an external byte-wide memory port. Software loads a source address, a destination address and a byte count through a small register file, then starts the transfer by writing the command register with its run bit set. One command bit selects the direction. Another asks for a completion interrupt.

The side of the transfer that lies in the buffer is addressed inside a fixed window that opens at 0x40000. Subtracting the window base from that address gives the buffer index. Before any byte moves, the engine checks that the whole range fits the window. A range that does not fit is refused and latched as a sticky error. The external-side address of every byte is ANDed with a programmable mask. The transfer starts a fixed number of cycles after the start write. It then moves one byte on each accepted memory-port handshake, walking both sides in ascending address order.

Top module: `dma_byte_engine`

## Requirements
- R1: After reset, source, destination, count and command read as zero, the mask reads 0x0FFFFFFF, the status word reads zero, and `irq`, `range_err` and `mem_req` are low.
- R2: The registers sit at offsets 0x80 (source), 0x88 (destination), 0x90 (count), 0x98 (command), 0xA0 (mask) and 0xA8 (status). A write of size 8 stores all 64 bits. A write of size 4 stores the low 32 bits, zero-extended. A write of any other size is ignored. A read of an unmapped offset returns all ones.
- R3: While command bit 0 (run) is set, writes to source, destination, count, command and mask are ignored.
- R4: A command write with bit 0 clear changes nothing and starts nothing.
- R5: After a command write that sets bit 0, `mem_req` stays low for START_DELAY cycles and rises after the START_DELAY-th clock edge that follows the write edge.
- R6: Command bit 1 at 0 copies external bytes into the buffer, and at 1 copies buffer bytes out. Byte i moves between external address base+i and buffer index (buffer address − 0x40000)+i. Exactly one byte moves per cycle in which `mem_req` and `mem_ack` are both high.
- R7: Every external address driven on `mem_addr` equals (external base + i) AND mask.
- R8: A transfer is refused when the buffer address is below 0x40000, when the count is zero, or when address+count exceeds 0x41000. A refused transfer sets the sticky `range_err` (status bit 31), clears run, issues no memory request and raises no interrupt. A range that ends exactly at 0x41000 is accepted.
- R9: The handshake that moves the last byte clears run. If command bit 2 was set, it also sets status bit 8 and `irq`. Otherwise `irq` is left unchanged.
- R10: Writing the status word clears bit 8 where the written bit 8 is one, and clears bit 31 where the written bit 31 is one.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wsize | input | 4 | Write access size in bytes (4 or 8 accepted) |
| reg_wdata | input | 64 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | 1 = byte write to external memory, 0 = byte read |
| mem_addr | output | 64 | Masked external byte address |
| mem_wdata | output | 8 | Byte written to external memory |
| mem_ack | input | 1 | Memory accepts the request this cycle; read data valid |
| mem_rdata | input | 8 | Byte read from external memory |
| irq | output | 1 | Completion interrupt (status bit 8) |
| range_err | output | 1 | Sticky range-refusal flag (status bit 31) |

## Verification
The bench probes the edges of the window check. A buffer address one byte below the base, a zero count, a range that ends exactly at the window end, and one that overruns it by a byte are all tried. An off-by-one comparison either refuses a legal full-tail copy or starts a copy that runs past the buffer. Writes sent while a copy is in flight must leave every register unchanged; a design with no lock would corrupt the running copy. The start delay is counted edge by edge, so a counter that is off by one shows up. A memory model that stalls, a narrow mask and a round trip out of the buffer and back catch address drift, masking applied at the wrong point, and bytes landing at the wrong buffer index.

// File: rtl/dma_byte_engine.sv
module dma_byte_engine #(
  parameter logic [63:0] BUF_BASE    = 64'h40000,
  parameter int          BUF_BYTES   = 4096,
  parameter logic [63:0] MASK_RESET  = 64'h0FFF_FFFF,
  parameter int          START_DELAY = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [3:0]  reg_wsize,
  input  logic [63:0] reg_wdata,
  input  logic [7:0]  rd_addr,
  output logic [63:0] rd_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        irq,
  output logic        range_err
);
  localparam int IW = $clog2(BUF_BYTES) + 1;
  localparam int DW = $clog2(START_DELAY + 1);
  localparam logic [64:0] WIN_END = {1'b0, BUF_BASE} + 65'(BUF_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} state_t;
  state_t state;

  logic [63:0] src_q, dst_q, cnt_q, cmd_q, mask_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] dly_q;
  logic [7:0] store [BUF_BYTES];

  wire run = cmd_q[0];
  wire out_dir = cmd_q[1];
  wire wr_ok = reg_we && (reg_wsize == 4'd4 || reg_wsize == 4'd8);
  wire [63:0] wval = (reg_wsize == 4'd8) ? reg_wdata : {32'b0, reg_wdata[31:0]};

  wire [63:0] buf_side = out_dir ? src_q : dst_q;
  wire [63:0] ext_side = out_dir ? dst_q : src_q;
  wire [64:0] buf_end  = {1'b0, buf_side} + {1'b0, cnt_q};
  wire range_ok = (buf_side >= BUF_BASE) && (buf_end > {1'b0, buf_side}) && (buf_end <= WIN_END);
  wire [IW-2:0] buf_idx = buf_side[IW-2:0] - BUF_BASE[IW-2:0] + idx_q[IW-2:0];
  wire last_byte = (idx_q + 1'b1) == cnt_q[IW-1:0];

  assign mem_req   = (state == S_XFER);
  assign mem_we    = out_dir;
  assign mem_addr  = (ext_side + 64'(idx_q)) & mask_q;
  assign mem_wdata = store[buf_idx];

  always_ff @(posedge clk)
    if (state == S_XFER && mem_ack && !out_dir) store[buf_idx] <= mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      src_q <= '0; dst_q <= '0; cnt_q <= '0; cmd_q <= '0;
      mask_q <= MASK_RESET;
      idx_q <= '0; dly_q <= '0;
      irq <= 1'b0; range_err <= 1'b0;
    end else begin
      if (wr_ok && reg_addr == 8'hA8) begin
        if (wval[8])  irq <= 1'b0;
        if (wval[31]) range_err <= 1'b0;
      end
      case (state)
        S_IDLE: if (wr_ok && !run) begin
          case (reg_addr)
            8'h80: src_q <= wval;
            8'h88: dst_q <= wval;
            8'h90: cnt_q <= wval;
            8'hA0: mask_q <= wval;
            8'h98: if (wval[0]) begin
              cmd_q <= wval;
              dly_q <= '0;
              state <= S_WAIT;
            end
            default: ;
          endcase
        end
        S_WAIT: begin
          if (dly_q == DW'(START_DELAY - 1)) begin
            if (range_ok) begin
              idx_q <= '0;
              state <= S_XFER;
            end else begin
              range_err <= 1'b1;
              cmd_q[0] <= 1'b0;
              state <= S_IDLE;
            end
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        S_XFER: if (mem_ack) begin
          if (last_byte) begin
            cmd_q[0] <= 1'b0;
            if (cmd_q[2]) irq <= 1'b1;
            state <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      8'h80: rd_data = src_q;
      8'h88: rd_data = dst_q;
      8'h90: rd_data = cnt_q;
      8'h98: rd_data = cmd_q;
      8'hA0: rd_data = mask_q;
      8'hA8: rd_data = {32'b0, range_err, 22'b0, irq, 8'b0};
      default: rd_data = '1;
    endcase
  end

  assert_req_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> run);
  assert_hold_while_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_regs_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(mask_q)));
  assert_addr_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & ~mask_q) == 64'b0));
  assert_refusal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(range_err) |-> (!run && !mem_req && !$rose(irq)));
  assert_irq_from_last_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_req && mem_ack));
endmodule

// File: tb/dma_byte_engine_bench.sv
`timescale 1ns/1ps
module dma_byte_engine_bench;
  localparam int SD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [3:0] reg_wsize = 4'd8;
  logic [63:0] reg_wdata = '0;
  logic [7:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic irq, range_err;

  int nchk = 0, nerr = 0;
  int nlog = 0, req_seen = 0, tick = 0;
  bit stall = 1'b1;
  logic [63:0] addr_log [64];
  logic [7:0] wr_log [1024];

  always #2.5 clk = ~clk;

  dma_byte_engine #(.START_DELAY(SD)) u_dma_byte_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wsize(reg_wsize), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq(irq), .range_err(range_err));

  function automatic logic [7:0] pat(input logic [63:0] a);
    return a[7:0] ^ {a[9:8], 6'h15};
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      req_seen++;
      tick++;
      mem_ack = !stall || (tick % 3 == 0);
      mem_rdata = pat(mem_addr);
      if (mem_ack) begin
        if (nlog < 64) addr_log[nlog] = mem_addr;
        if (mem_we) wr_log[mem_addr[9:0]] = mem_wdata;
        nlog++;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [3:0] sz);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wsize = sz;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic clear_logs();
    @(posedge clk);
    #1;
    nlog = 0; req_seen = 0;
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(8'h98, v);
      if (!v[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [63:0] v;
    @(negedge clk);
    rd(8'h80, v); chk("R1 src", v, 64'h0);
    rd(8'h98, v); chk("R1 cmd", v, 64'h0);
    rd(8'hA0, v); chk("R1 mask", v, 64'h0FFF_FFFF);
    rd(8'hA8, v); chk("R1 status", v, 64'h0);
    chk("R1 outputs", {61'b0, irq, range_err, mem_req}, 64'h0);
    rd(8'h40, v); chk("R2 unmapped", v, '1);
  endtask

  task automatic t_regs();
    logic [63:0] v;
    wr(8'h80, 64'h1122_3344_5566_7788, 4'd8);
    rd(8'h80, v); chk("R2 wide write", v, 64'h1122_3344_5566_7788);
    wr(8'h88, 64'hFFFF_FFFF_ABCD_0123, 4'd4);
    rd(8'h88, v); chk("R2 narrow write", v, 64'h0000_0000_ABCD_0123);
    wr(8'h90, 64'h5, 4'd2);
    rd(8'h90, v); chk("R2 bad size", v, 64'h0);
  endtask

  task automatic t_no_run_bit();
    logic [63:0] v;
    clear_logs();
    wr(8'h98, 64'h6, 4'd4);
    repeat (SD + 4) @(negedge clk);
    chk("R4 no request", 64'(req_seen), 64'h0);
    rd(8'h98, v); chk("R4 cmd unchanged", v, 64'h0);
  endtask

  task automatic t_copy_in();
    logic [63:0] v;
    int bad;
    wr(8'h80, 64'h1000_0120, 4'd8);
    wr(8'h88, 64'h40010, 4'd8);
    wr(8'h90, 64'd8, 4'd8);
    clear_logs();
    wr(8'h98, 64'h5, 4'd4);
    bad = 0;
    if (mem_req) bad++;
    for (int i = 0; i < SD - 1; i++) begin
      @(negedge clk);
      if (mem_req) bad++;
    end
    chk("R5 quiet during delay", 64'(bad), 64'h0);
    @(negedge clk);
    chk("R5 request after delay", {63'b0, mem_req}, 64'h1);
    wr(8'h80, 64'hDEAD, 4'd8);
    wr(8'hA0, 64'hF, 4'd4);
    rd(8'h98, v); chk("R3 still running", {63'b0, v[0]}, 64'h1);
    rd(8'h80, v); chk("R3 src locked", v, 64'h1000_0120);
    rd(8'hA0, v); chk("R3 mask locked", v, 64'h0FFF_FFFF);
    wait_idle();
    rd(8'h98, v); chk("R9 run cleared", v, 64'h4);
    chk("R9 irq raised", {63'b0, irq}, 64'h1);
    rd(8'hA8, v); chk("R9 status bit 8", v, 64'h100);
    chk("R6 handshakes", 64'(nlog), 64'd8);
    bad = 0;
    for (int i = 0; i < 8; i++) if (addr_log[i] !== 64'h120 + 64'(i)) bad++;
    chk("R7 masked ascending addr", 64'(bad), 64'h0);
    wr(8'hA8, 64'h100, 4'd4);
    chk("R10 irq cleared", {63'b0, irq}, 64'h0);
  endtask

  task automatic t_copy_out();
    logic [63:0] v;
    int bad;
    stall = 1'b0;
    wr(8'h80, 64'h40010, 4'd8);
    wr(8'h88, 64'h300, 4'd8);
    clear_logs();
    wr(8'h98, 64'h3, 4'd4);
    wait_idle();
    bad = 0;
    for (int i = 0; i < 8; i++) if (wr_log[10'h300 + 10'(i)] !== pat(64'h120 + 64'(i))) bad++;
    chk("R6 round trip bytes", 64'(bad), 64'h0);
    chk("R9 no irq without bit 2", {63'b0, irq}, 64'h0);
    rd(8'h98, v); chk("R9 run cleared out", v, 64'h2);
    stall = 1'b1;
  endtask

  task automatic t_mask();
    wr(8'hA0, 64'hFF, 4'd4);
    wr(8'h88, 64'h3F5, 4'd8);
    wr(8'h90, 64'd2, 4'd8);
    clear_logs();
    wr(8'h98, 64'h3, 4'd4);
    wait_idle();
    chk("R7 narrow mask addr", addr_log[1], 64'hF6);
    chk("R7 narrow mask data", {56'b0, wr_log[10'hF5]}, {56'b0, pat(64'h120)});
    wr(8'hA0, 64'h0FFF_FFFF, 4'd8);
  endtask

  task automatic range_case(input logic [63:0] dst, input logic [63:0] cnt, input bit refuse);
    logic [63:0] v;
    wr(8'hA8, 64'h8000_0100, 4'd4);
    wr(8'h80, 64'h200, 4'd8);
    wr(8'h88, dst, 4'd8);
    wr(8'h90, cnt, 4'd8);
    clear_logs();
    wr(8'h98, 64'h5, 4'd4);
    wait_idle();
    chk("R8 error flag", {63'b0, range_err}, {63'b0, refuse});
    rd(8'hA8, v); chk("R8 status bit 31", {63'b0, v[31]}, {63'b0, refuse});
    if (refuse) begin
      chk("R8 no request", 64'(req_seen), 64'h0);
      chk("R8 no irq", {63'b0, irq}, 64'h0);
    end else begin
      chk("R8 accepted length", 64'(nlog), cnt);
    end
  endtask

  task automatic t_ranges();
    range_case(64'h3FFFF, 64'd4, 1'b1);
    range_case(64'h40000, 64'd0, 1'b1);
    range_case(64'h40FFC, 64'd4, 1'b0);
    range_case(64'h40FFD, 64'd4, 1'b1);
    wr(8'hA8, 64'h8000_0000, 4'd4);
    chk("R10 error cleared", {63'b0, range_err}, 64'h0);
  endtask

  bit finished = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_no_run_bit();
    t_copy_in();
    t_copy_out();
    t_mask();
    t_ranges();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule